// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This block forms the memory address for one load or store of a 32-bit RISC core with sixteen general registers. The decoder gives it an addressing-mode code, an operand size, the base register's value, the value of register zero (the index register), the program counter and an 8-bit displacement. The address is produced combinationally in the same cycle. It is flagged when it is misaligned for the operand size or when the size code is reserved.

The auto-increment and auto-decrement modes also produce an updated base value. That value is registered into a writeback port on the clock edge where the access is reported complete. A pre-decrement access uses the already-stepped value as its address. A post-increment access uses the original base and steps it afterwards. The step is 1, 2 or 4 bytes, scaled by the operand size. All arithmetic wraps modulo 2^32.

Top module: `ls_ea_unit`

## Requirements
- R1: Mode codes 000 (register direct) and the unused codes 110 and 111 give addrValid=0, effAddr=0, alignErr=0 and sizeErr=0, and never cause a writeback.
- R2: Mode 001 (indirect) gives effAddr equal to baseVal, addrValid=1 and no writeback.
- R3: Mode 010 (post-increment) gives effAddr equal to baseVal. The value written back is baseVal plus the step: 1 for size 00 (byte), 2 for size 01 (word) or 4 for size 10 (longword).
- R4: Mode 011 (pre-decrement) gives effAddr equal to baseVal minus the step. The same value is written back.
- R5: Mode 100 (indexed) gives effAddr = idxVal + baseVal, with no writeback.
- R6: Mode 101 (PC-relative) gives effAddr = P + 4 + disp×step, where disp is zero-extended. P is pcVal with bits [1:0] cleared for size 10, and pcVal unchanged otherwise.
- R7: On a rising edge where accessDone=1 and a post-increment or pre-decrement access has no fault, the outputs after that edge are wbEn=1, wbData equal to the stepped value and wbIdx equal to baseIdx. After any other edge, wbEn=0 and wbData and wbIdx keep their values.
- R8: alignErr=1 when addrValid=1 and either a size-01 address has bit 0 set or a size-10 address has bits [1:0] not equal to 00. A faulting access writes nothing back.
- R9: Size code 11 in any memory mode gives sizeErr=1 and alignErr=0. It uses a step and displacement scale of 0, and writes nothing back.
- R10: Address and writeback arithmetic wraps modulo 2^32 without any flag.
- R11: After reset, wbEn=0, wbData=0 and wbIdx=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeCode | input | 3 | Addressing mode |
| opSize | input | 2 | Operand size: 00 byte, 01 word, 10 longword, 11 reserved |
| baseVal | input | 32 | Base register contents |
| baseIdx | input | 4 | Base register number |
| idxVal | input | 32 | Index register (register zero) contents |
| pcVal | input | 32 | Program counter of the instruction |
| disp | input | 8 | Unsigned displacement |
| accessDone | input | 1 | Access completes at this edge |
| effAddr | output | 32 | Effective address |
| addrValid | output | 1 | A memory address is produced |
| alignErr | output | 1 | Address misaligned for its size |
| sizeErr | output | 1 | Reserved size code used |
| wbEn | output | 1 | Registered base writeback enable |
| wbData | output | 32 | Registered new base value |
| wbIdx | output | 4 | Registered base register number |

## Verification
A stepped writeback request and an alignment fault can arise in the same cycle. The bench provokes this by giving post-increment and pre-decrement accesses an odd or non-multiple-of-four base while accessDone is high, including a pre-decrement whose stepped value is the misaligned one. It judges the result by requiring that the address still follows the mode, that alignErr is high, and that after the edge wbEn is low while wbData and wbIdx keep the previous commit. A behavioural model in the bench tracks the expected committed state across back-to-back and random accesses.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam logic [2:0] MODE_DIRECT  = 3'b000;
  localparam logic [2:0] MODE_IND     = 3'b001;
  localparam logic [2:0] MODE_POSTINC = 3'b010;
  localparam logic [2:0] MODE_PREDEC  = 3'b011;
  localparam logic [2:0] MODE_INDEX   = 3'b100;
  localparam logic [2:0] MODE_PCREL   = 3'b101;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_WORD = 2'b01;
  localparam logic [1:0] SZ_LONG = 2'b10;
  localparam logic [1:0] SZ_BAD  = 2'b11;

  typedef struct packed {
    logic       memAccess;
    logic       addIdx;
    logic       selPc;
    logic       useNew;
    logic       stepDown;
    logic       wbReq;
    logic       alignPcLow;
    logic       sizeBad;
    logic [2:0] stepBytes;
  } eaStrobes_t;
endpackage

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] modeCode,
  input  logic [1:0] opSize,
  output eaStrobes_t strobes
);
  logic [2:0] sizeStep;

  always_comb begin
    unique case (opSize)
      SZ_BYTE: sizeStep = 3'd1;
      SZ_WORD: sizeStep = 3'd2;
      SZ_LONG: sizeStep = 3'd4;
      default: sizeStep = 3'd0;
    endcase
  end

  always_comb begin
    strobes = '0;
    unique case (modeCode)
      MODE_IND:     strobes.memAccess = 1'b1;
      MODE_POSTINC: begin
        strobes.memAccess = 1'b1;
        strobes.wbReq     = 1'b1;
      end
      MODE_PREDEC: begin
        strobes.memAccess = 1'b1;
        strobes.wbReq     = 1'b1;
        strobes.useNew    = 1'b1;
        strobes.stepDown  = 1'b1;
      end
      MODE_INDEX: begin
        strobes.memAccess = 1'b1;
        strobes.addIdx    = 1'b1;
      end
      MODE_PCREL: begin
        strobes.memAccess  = 1'b1;
        strobes.selPc      = 1'b1;
        strobes.alignPcLow = (opSize == SZ_LONG);
      end
      default: strobes = '0;
    endcase
    if (strobes.memAccess) begin
      strobes.stepBytes = sizeStep;
      strobes.sizeBad   = (opSize == SZ_BAD);
    end
  end

  // R2 R5 R6: only the two stepping modes request writeback
  p_wb_modes_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wbReq |-> (modeCode == MODE_POSTINC || modeCode == MODE_PREDEC));

  p_size_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sizeBad |-> (opSize == SZ_BAD && strobes.stepBytes == 3'd0));

  p_direct_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == MODE_DIRECT || modeCode[2:1] == 2'b11) |-> !strobes.memAccess && !strobes.wbReq);
endmodule

// File: rtl/ea_datapath.sv
module ea_datapath
  import ea_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DISP_W    = 8,
  parameter int REG_IDX_W = 4,
  parameter int PC_AHEAD  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  eaStrobes_t           strobes,
  input  logic [ADDR_W-1:0]    baseVal,
  input  logic [REG_IDX_W-1:0] baseIdx,
  input  logic [ADDR_W-1:0]    idxVal,
  input  logic [ADDR_W-1:0]    pcVal,
  input  logic [DISP_W-1:0]    disp,
  input  logic                 accessDone,
  output logic [ADDR_W-1:0]    effAddr,
  output logic                 alignErr,
  output logic                 wbEn,
  output logic [ADDR_W-1:0]    wbData,
  output logic [REG_IDX_W-1:0] wbIdx
);
  localparam logic [ADDR_W-1:0] PC_OFFSET = ADDR_W'(PC_AHEAD);

  logic [ADDR_W-1:0] stepExt;
  logic [ADDR_W-1:0] newBase;
  logic [ADDR_W-1:0] pcBase;
  logic [ADDR_W-1:0] dispScaled;
  logic              wbAllowed;

  assign stepExt    = ADDR_W'(strobes.stepBytes);
  assign newBase    = strobes.stepDown ? (baseVal - stepExt) : (baseVal + stepExt);
  assign pcBase     = strobes.alignPcLow ? {pcVal[ADDR_W-1:2], 2'b00} : pcVal;
  assign dispScaled = ADDR_W'(disp) * stepExt;

  always_comb begin
    if (!strobes.memAccess)   effAddr = '0;
    else if (strobes.selPc)   effAddr = pcBase + PC_OFFSET + dispScaled;
    else if (strobes.addIdx)  effAddr = idxVal + baseVal;
    else if (strobes.useNew)  effAddr = newBase;
    else                      effAddr = baseVal;
  end

  always_comb begin
    alignErr = 1'b0;
    if (strobes.memAccess) begin
      unique case (strobes.stepBytes)
        3'd2:    alignErr = effAddr[0];
        3'd4:    alignErr = |effAddr[1:0];
        default: alignErr = 1'b0;
      endcase
    end
  end

  assign wbAllowed = strobes.wbReq && !alignErr && !strobes.sizeBad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbEn   <= 1'b0;
      wbData <= '0;
      wbIdx  <= '0;
    end else begin
      wbEn <= accessDone && wbAllowed;
      if (accessDone && wbAllowed) begin
        wbData <= newBase;
        wbIdx  <= baseIdx;
      end
    end
  end

  p_wb_after_commit_r7: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> $past(accessDone));

  p_wb_blocked_fault_r8: assert property (@(posedge clk) disable iff (!rstN)
    (accessDone && (alignErr || strobes.sizeBad)) |=> !wbEn);

  p_post_uses_old_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wbReq && !strobes.stepDown) |-> effAddr == baseVal);

  p_pre_uses_new_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wbReq && strobes.stepDown) |-> (effAddr + stepExt) == baseVal);

  p_no_addr_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.memAccess |-> (effAddr == '0 && !alignErr));
endmodule

// File: rtl/ls_ea_unit.sv
module ls_ea_unit
  import ea_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DISP_W    = 8,
  parameter int REG_IDX_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           modeCode,
  input  logic [1:0]           opSize,
  input  logic [ADDR_W-1:0]    baseVal,
  input  logic [REG_IDX_W-1:0] baseIdx,
  input  logic [ADDR_W-1:0]    idxVal,
  input  logic [ADDR_W-1:0]    pcVal,
  input  logic [DISP_W-1:0]    disp,
  input  logic                 accessDone,
  output logic [ADDR_W-1:0]    effAddr,
  output logic                 addrValid,
  output logic                 alignErr,
  output logic                 sizeErr,
  output logic                 wbEn,
  output logic [ADDR_W-1:0]    wbData,
  output logic [REG_IDX_W-1:0] wbIdx
);
  eaStrobes_t strobes;

  ea_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modeCode (modeCode),
    .opSize   (opSize),
    .strobes  (strobes)
  );

  ea_datapath #(
    .ADDR_W    (ADDR_W),
    .DISP_W    (DISP_W),
    .REG_IDX_W (REG_IDX_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .baseVal    (baseVal),
    .baseIdx    (baseIdx),
    .idxVal     (idxVal),
    .pcVal      (pcVal),
    .disp       (disp),
    .accessDone (accessDone),
    .effAddr    (effAddr),
    .alignErr   (alignErr),
    .wbEn       (wbEn),
    .wbData     (wbData),
    .wbIdx      (wbIdx)
  );

  assign addrValid = strobes.memAccess;
  assign sizeErr   = strobes.sizeBad;

  p_size_err_mem_r9: assert property (@(posedge clk) disable iff (!rstN)
    sizeErr |-> (addrValid && !alignErr));
endmodule

// File: tb/test_ls_ea_unit.sv
module test_ls_ea_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  modeCode = '0;
  logic [1:0]  opSize = '0;
  logic [31:0] baseVal = '0;
  logic [3:0]  baseIdx = '0;
  logic [31:0] idxVal = '0;
  logic [31:0] pcVal = '0;
  logic [7:0]  disp = '0;
  logic        accessDone = 1'b0;
  logic [31:0] effAddr;
  logic        addrValid, alignErr, sizeErr, wbEn;
  logic [31:0] wbData;
  logic [3:0]  wbIdx;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic        expWbEn = 1'b0;
  logic [31:0] expWbData = '0;
  logic [3:0]  expWbIdx = '0;

  always #4 clk = ~clk;

  ls_ea_unit i_ls_ea_unit (
    .clk(clk), .rstN(rstN), .modeCode(modeCode), .opSize(opSize),
    .baseVal(baseVal), .baseIdx(baseIdx), .idxVal(idxVal), .pcVal(pcVal),
    .disp(disp), .accessDone(accessDone), .effAddr(effAddr),
    .addrValid(addrValid), .alignErr(alignErr), .sizeErr(sizeErr),
    .wbEn(wbEn), .wbData(wbData), .wbIdx(wbIdx)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural reference for one access
  task automatic model(input logic [2:0] m, input logic [1:0] s, input logic [31:0] b,
                       input logic [31:0] r0, input logic [31:0] pc, input logic [7:0] d,
                       output logic [31:0] ea, output logic vld, output logic al,
                       output logic se, output logic wb, output logic [31:0] nv);
    logic [31:0] step;
    step = (s == 2'd0) ? 32'd1 : (s == 2'd1) ? 32'd2 : (s == 2'd2) ? 32'd4 : 32'd0;
    vld = (m >= 3'd1 && m <= 3'd5);
    ea = 32'd0;
    nv = 32'd0;
    case (m)
      3'd1: ea = b;
      3'd2: begin ea = b; nv = b + step; end
      3'd3: begin nv = b - step; ea = nv; end
      3'd4: ea = r0 + b;
      3'd5: ea = ((s == 2'd2) ? (pc & 32'hFFFF_FFFC) : pc) + 32'd4 + {24'd0, d} * step;
      default: ea = 32'd0;
    endcase
    al = vld && ((s == 2'd1 && ea[0]) || (s == 2'd2 && ea[1:0] != 2'b00));
    se = vld && (s == 2'd3);
    wb = (m == 3'd2 || m == 3'd3) && !al && !se;
  endtask

  task automatic access(input string req, input logic [2:0] m, input logic [1:0] s,
                        input logic [31:0] b, input logic [3:0] bi, input logic [31:0] r0,
                        input logic [31:0] pc, input logic [7:0] d, input logic done);
    logic [31:0] ea, nv;
    logic vld, al, se, wb;
    @(negedge clk);
    modeCode = m; opSize = s; baseVal = b; baseIdx = bi; idxVal = r0;
    pcVal = pc; disp = d; accessDone = done;
    model(m, s, b, r0, pc, d, ea, vld, al, se, wb, nv);
    #1;
    check(req, "effAddr", effAddr, ea);
    check(req, "addrValid", {31'd0, addrValid}, {31'd0, vld});
    check(req, "alignErr", {31'd0, alignErr}, {31'd0, al});
    check(req, "sizeErr", {31'd0, sizeErr}, {31'd0, se});
    @(posedge clk);
    expWbEn = done && wb;
    if (done && wb) begin
      expWbData = nv;
      expWbIdx = bi;
    end
    #1;
    check(req, "wbEn", {31'd0, wbEn}, {31'd0, expWbEn});
    check(req, "wbData", wbData, expWbData);
    check(req, "wbIdx", {28'd0, wbIdx}, {28'd0, expWbIdx});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R11", "wbEn reset", {31'd0, wbEn}, 32'd0);
    check("R11", "wbData reset", wbData, 32'd0);
    check("R11", "wbIdx reset", {28'd0, wbIdx}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R3 / R4 baseline commits
    access("R3", 3'd2, 2'd0, 32'h0000_2001, 4'd3, 32'd0, 32'd0, 8'd0, 1'b1);
    access("R3", 3'd2, 2'd1, 32'h0000_3000, 4'd4, 32'd0, 32'd0, 8'd0, 1'b1);
    access("R3", 3'd2, 2'd2, 32'h0000_4000, 4'd5, 32'd0, 32'd0, 8'd0, 1'b1);
    access("R4", 3'd3, 2'd0, 32'h0000_5000, 4'd6, 32'd0, 32'd0, 8'd0, 1'b1);
    access("R4", 3'd3, 2'd1, 32'h0000_6000, 4'd7, 32'd0, 32'd0, 8'd0, 1'b1);
    access("R4", 3'd3, 2'd2, 32'h0000_7000, 4'd8, 32'd0, 32'd0, 8'd0, 1'b1);
    // R1 direct and unused codes: done high must not write back
    access("R1", 3'd0, 2'd2, 32'h1234_5678, 4'd9, 32'd1, 32'd2, 8'd3, 1'b1);
    access("R1", 3'd6, 2'd1, 32'h0000_0100, 4'd9, 32'd1, 32'd2, 8'd3, 1'b1);
    access("R1", 3'd7, 2'd3, 32'h0000_0100, 4'd9, 32'd1, 32'd2, 8'd3, 1'b1);
    // R2 indirect and R5 indexed
    access("R2", 3'd1, 2'd1, 32'h0000_1000, 4'd1, 32'd0, 32'd0, 8'd0, 1'b1);
    access("R5", 3'd4, 2'd2, 32'h0000_2000, 4'd2, 32'h10, 32'd0, 8'd0, 1'b1);
    // R6 PC-relative literal addressing
    access("R6", 3'd5, 2'd1, 32'd0, 4'd0, 32'd0, 32'h0000_1002, 8'h7F, 1'b1);
    access("R6", 3'd5, 2'd2, 32'd0, 4'd0, 32'd0, 32'h0000_1002, 8'hFF, 1'b1);
    access("R6", 3'd5, 2'd0, 32'd0, 4'd0, 32'd0, 32'h0000_1003, 8'h03, 1'b1);
    // R7 no commit without done; then back-to-back commits
    access("R7", 3'd2, 2'd2, 32'h0000_8000, 4'd10, 32'd0, 32'd0, 8'd0, 1'b0);
    access("R7", 3'd3, 2'd2, 32'h0000_9000, 4'd11, 32'd0, 32'd0, 8'd0, 1'b1);
    access("R7", 3'd2, 2'd1, 32'h0000_A000, 4'd12, 32'd0, 32'd0, 8'd0, 1'b1);
    // R8 stepping request and misalignment together
    access("R8", 3'd2, 2'd1, 32'h0000_3001, 4'd13, 32'd0, 32'd0, 8'd0, 1'b1);
    access("R8", 3'd2, 2'd2, 32'h0000_4002, 4'd14, 32'd0, 32'd0, 8'd0, 1'b1);
    access("R8", 3'd3, 2'd2, 32'h0000_4006, 4'd15, 32'd0, 32'd0, 8'd0, 1'b1);
    access("R8", 3'd4, 2'd2, 32'h0000_0001, 4'd1, 32'h2, 32'd0, 8'd0, 1'b1);
    // R9 reserved size
    access("R9", 3'd2, 2'd3, 32'h0000_4001, 4'd2, 32'd0, 32'd0, 8'd0, 1'b1);
    access("R9", 3'd5, 2'd3, 32'd0, 4'd2, 32'd0, 32'h0000_2001, 8'h44, 1'b1);
    // R10 wraparound
    access("R10", 3'd3, 2'd2, 32'h0000_0000, 4'd3, 32'd0, 32'd0, 8'd0, 1'b1);
    access("R10", 3'd2, 2'd0, 32'hFFFF_FFFF, 4'd4, 32'd0, 32'd0, 8'd0, 1'b1);
    access("R10", 3'd5, 2'd2, 32'd0, 4'd0, 32'd0, 32'hFFFF_FFFE, 8'h01, 1'b1);
    // R7 random mix against the model
    for (int i = 0; i < 300; i++) begin
      access("R7", 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), $urandom,
             4'($urandom_range(0, 15)), $urandom, $urandom, 8'($urandom_range(0, 255)),
             1'($urandom_range(0, 1)));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule